// File: doc/BRIEF.md
# 8-bit ALU with Flag Update

This block is the arithmetic and logic stage of a small 8-bit processor core. On each accepted operation it takes an operation code, two 8-bit operands and the current flags byte. It computes a result, says whether that result should be written back, and forms the next flags byte. Each operation class changes only its own subset of the flags; the rest pass through unchanged. The result, the write-enable and the new flags are all registered, so they appear one clock after the operation is presented.

The flags byte holds zero (ZF), carry (CF), overflow (OF), sign (SF), interrupt-disable (IF) and branch (BF). This block never changes IF or BF; it only carries them through. Increment and decrement signal an 8-bit wrap on both CF and OF. Code that builds 16-bit values from register pairs can therefore use an overflow test to step the high register. The bit test sets ZF when the chosen bit is one.

Register file, instruction decode and the conditional-skip control sit outside this block.

Top module: `alu8_flag_unit`

## Requirements
- R1: A synchronous active-low reset clears `out_valid`, `res_q`, `res_we` and `flags_q` to zero.
- R2: When `in_valid` is high at a rising edge, `out_valid`, `res_q`, `res_we` and `flags_q` for that operation appear after that edge. `out_valid` is low after any edge where `in_valid` was low.
- R3: The codes AND=0, OR=1 and XOR=2 write the bitwise result (`res_we`=1) and update only ZF and SF.
- R4: INC=3 writes a+1 and DEC=4 writes a-1. Both set CF and OF together, and only when the value wraps: INC of 0xFF gives 0x00, DEC of 0x00 gives 0xFF. Otherwise CF and OF are cleared.
- R5: ADD=5 writes a+b, with CF as the unsigned carry out of bit 7. SUB=6 writes a-b, with CF as the borrow (a<b unsigned). For both, OF is the two's-complement signed overflow.
- R6: CMP=7 sets ZF, CF, OF and SF exactly as SUB would, but holds `res_we` low.
- R7: SHL=8, SHR=9, ROL=10 and ROR=11 shift or rotate `opnd_a` by the count in `opnd_b[2:0]` and write the result. CF becomes the last bit moved out of the end. OF is kept.
- R8: A shift or rotate with count 0 returns `opnd_a` unchanged and clears CF.
- R9: BIT=12 sets ZF to the value of `opnd_a[opnd_b[2:0]]` and keeps every other flag. It holds `res_we` low and returns `opnd_a` on `res_q`.
- R10: For operations that update ZF and SF from a value (all except BIT and unused codes), ZF is 1 exactly when the 8-bit value is zero, and SF equals its bit 7. For CMP that value is the difference.
- R11: Flags byte layout: bit0 ZF, bit1 CF, bit2 OF, bit3 SF, bit4 IF, bit5 BF. IF and BF are copied from `flags_cur`. Bits 7:6 of `flags_q` are always zero.
- R12: Codes 13 to 15 hold `res_we` low, return 0 on `res_q`, and pass `flags_cur[5:0]` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand; bits 2:0 are the count or bit index |
| flags_cur | input | 8 | Current flags byte |
| out_valid | output | 1 | Registered outputs belong to an operation |
| res_q | output | 8 | Registered result |
| res_we | output | 1 | Result should be written back |
| flags_q | output | 8 | Registered next flags byte |

## Verification
The only state is the output register, so any fault shows on the ports one clock after the operation that caused it. No error can stay hidden for more than that one cycle. The mask-related failures are the dangerous ones. A wrong per-class mask shows up as a preserved flag (CF/OF under logic, OF under shifts, IF/BF always) changing value. A wrong shifter shows up as a CF that does not match the last bit moved out. The bench therefore drives flags_cur with patterns that differ from every computed flag value, so that a flag that should have been kept visibly flips. It also covers the wrap and count-0 corners directly.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag bit positions for the ALU.
// Assumes a 4-bit operation code; codes above OP_BIT are unused.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_XOR = 4'd2,
        OP_INC = 4'd3,
        OP_DEC = 4'd4,
        OP_ADD = 4'd5,
        OP_SUB = 4'd6,
        OP_CMP = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11,
        OP_BIT = 4'd12
    } alu_op_e;

    localparam int FLAG_W = 8;
    localparam int FL_Z   = 0;
    localparam int FL_C   = 1;
    localparam int FL_O   = 2;
    localparam int FL_S   = 3;
    localparam int FL_I   = 4;
    localparam int FL_B   = 5;

endpackage

// File: rtl/alu8_arith.sv
// Module: bitwise logic plus increment, decrement, add and subtract.
// Produces the raw value and the carry/borrow and overflow candidates.
// Assumes the caller decides which flags the operation may touch.
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cf,
    output logic         of
);
    import alu8_pkg::*;

    logic [W:0] sum_x;
    logic [W:0] dif_x;
    logic [W:0] inc_x;
    logic [W:0] dec_x;

    // Purpose: compute all arithmetic candidates and pick by operation.
    always_comb begin
        sum_x = {1'b0, a} + {1'b0, b};
        dif_x = {1'b0, a} - {1'b0, b};
        inc_x = {1'b0, a} + {{W{1'b0}}, 1'b1};
        dec_x = {1'b0, a} - {{W{1'b0}}, 1'b1};
        res   = '0;
        cf    = 1'b0;
        of    = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_INC: begin
                res = inc_x[W-1:0];
                cf  = inc_x[W];
                of  = inc_x[W];
            end
            OP_DEC: begin
                res = dec_x[W-1:0];
                cf  = dec_x[W];
                of  = dec_x[W];
            end
            OP_ADD: begin
                res = sum_x[W-1:0];
                cf  = sum_x[W];
                of  = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
            end
            OP_SUB, OP_CMP: begin
                res = dif_x[W-1:0];
                cf  = dif_x[W];
                of  = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu8_shifter.sv
// Module: logical shift and rotate by a count of 0 to W-1.
// CF is the last bit moved out of the end; a zero count gives CF=0.
// Assumes op is one of the four shift codes when its result is used.
module alu8_shifter #(
    parameter int W     = 8,
    parameter int CNT_W = $clog2(W)
) (
    input  logic [3:0]       op,
    input  logic [W-1:0]     a,
    input  logic [CNT_W-1:0] cnt,
    output logic [W-1:0]     res,
    output logic             cf
);
    import alu8_pkg::*;

    logic [W:0]     shl_x;
    logic [W:0]     shr_x;
    logic [2*W-1:0] rol_x;
    logic [2*W-1:0] ror_x;
    logic           cnt_nz;

    // Purpose: form extended shifts whose spare bit captures the bit moved out.
    always_comb begin
        shl_x  = {1'b0, a} << cnt;
        shr_x  = {a, 1'b0} >> cnt;
        rol_x  = {a, a} << cnt;
        ror_x  = {a, a} >> cnt;
        cnt_nz = (cnt != '0);
        res    = a;
        cf     = 1'b0;
        case (op)
            OP_SHL: begin
                res = shl_x[W-1:0];
                cf  = shl_x[W];
            end
            OP_SHR: begin
                res = shr_x[W:1];
                cf  = shr_x[0];
            end
            OP_ROL: begin
                res = rol_x[2*W-1:W];
                cf  = cnt_nz & rol_x[W];
            end
            OP_ROR: begin
                res = ror_x[W-1:0];
                cf  = cnt_nz & ror_x[W-1];
            end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_outreg.sv
// Module: output register stage for result, write-enable and flags.
// Assumes a synchronous active-low reset that clears every output.
module alu8_outreg #(
    parameter int W  = 8,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_valid,
    input  logic [W-1:0]  d_res,
    input  logic          d_we,
    input  logic [FW-1:0] d_flags,
    output logic          q_valid,
    output logic [W-1:0]  q_res,
    output logic          q_we,
    output logic [FW-1:0] q_flags
);

    // Purpose: capture one operation's outputs per accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_res   <= '0;
            q_we    <= 1'b0;
            q_flags <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) begin
                q_res   <= d_res;
                q_we    <= d_we;
                q_flags <= d_flags;
            end
        end
    end

    // R2: valid follows the accepted input by one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |=> q_valid);
    p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !d_valid |=> !q_valid);

endmodule

// File: rtl/alu8_flag_unit.sv
// Module: top of the 8-bit ALU. Selects the arithmetic or shift result and
// merges the new flags into the current byte per operation class, then
// registers everything.
// Assumes IF and BF are owned elsewhere and only passed through here.
module alu8_flag_unit #(
    parameter int W     = 8,
    parameter int CNT_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [7:0]   flags_cur,
    output logic         out_valid,
    output logic [W-1:0] res_q,
    output logic         res_we,
    output logic [7:0]   flags_q
);
    import alu8_pkg::*;

    logic [W-1:0]      ar_res;
    logic              ar_cf;
    logic              ar_of;
    logic [W-1:0]      sh_res;
    logic              sh_cf;
    logic [CNT_W-1:0]  cnt;
    logic [W-1:0]      nx_res;
    logic              nx_we;
    logic [FLAG_W-1:0] nx_flags;
    logic              upd_zs;

    assign cnt = opnd_b[CNT_W-1:0];

    alu8_arith #(.W(W)) i_arith (
        .op  (op_sel),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (ar_res),
        .cf  (ar_cf),
        .of  (ar_of)
    );

    alu8_shifter #(.W(W), .CNT_W(CNT_W)) i_shift (
        .op  (op_sel),
        .a   (opnd_a),
        .cnt (cnt),
        .res (sh_res),
        .cf  (sh_cf)
    );

    // Purpose: choose the result and write only the flags this class owns.
    always_comb begin
        nx_flags = flags_cur & 8'h3F;
        nx_res   = '0;
        nx_we    = 1'b0;
        upd_zs   = 1'b0;
        case (op_sel)
            OP_AND, OP_OR, OP_XOR: begin
                nx_res = ar_res;
                nx_we  = 1'b1;
                upd_zs = 1'b1;
            end
            OP_INC, OP_DEC, OP_ADD, OP_SUB, OP_CMP: begin
                nx_res         = ar_res;
                nx_we          = (op_sel != OP_CMP);
                upd_zs         = 1'b1;
                nx_flags[FL_C] = ar_cf;
                nx_flags[FL_O] = ar_of;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                nx_res         = sh_res;
                nx_we          = 1'b1;
                upd_zs         = 1'b1;
                nx_flags[FL_C] = sh_cf;
            end
            OP_BIT: begin
                nx_res         = opnd_a;
                nx_flags[FL_Z] = opnd_a[cnt];
            end
            default: nx_res = '0;
        endcase
        if (upd_zs) begin
            nx_flags[FL_Z] = (nx_res == '0);
            nx_flags[FL_S] = nx_res[W-1];
        end
    end

    alu8_outreg #(.W(W), .FW(FLAG_W)) i_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_res   (nx_res),
        .d_we    (nx_we),
        .d_flags (nx_flags),
        .q_valid (out_valid),
        .q_res   (res_q),
        .q_we    (res_we),
        .q_flags (flags_q)
    );

    // R11: upper flag bits stay zero, IF and BF are carried through
    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> flags_q[7:6] == 2'b00);
    p_keep_if_bf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> flags_q[FL_B:FL_I] == $past(flags_cur[FL_B:FL_I]));
    // R3: logic operations leave CF and OF alone
    p_logic_cf_of_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel inside {OP_AND, OP_OR, OP_XOR})
        |=> flags_q[FL_O:FL_C] == $past(flags_cur[FL_O:FL_C]));
    // R7: shifts and rotates keep OF
    p_shift_of_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel inside {OP_SHL, OP_SHR, OP_ROL, OP_ROR})
        |=> flags_q[FL_O] == $past(flags_cur[FL_O]));
    // R8: count zero returns the operand and clears CF
    p_count0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel inside {OP_SHL, OP_SHR, OP_ROL, OP_ROR} && cnt == '0)
        |=> res_q == $past(opnd_a) && !flags_q[FL_C]);
    // R6: compare never writes back
    p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_CMP) |=> !res_we);
    // R9: bit test touches only ZF and does not write
    p_bit_only_zf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_BIT)
        |=> flags_q[FL_B:FL_C] == $past(flags_cur[FL_B:FL_C]) && !res_we);
    // R10: written results agree with ZF and SF
    p_zf_sf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_we)
        |-> flags_q[FL_Z] == (res_q == '0) && flags_q[FL_S] == res_q[W-1]);

endmodule

// File: tb/test_alu8_flag_unit.sv
module test_alu8_flag_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] res;
        logic       we;
        logic [7:0] fl;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [3:0] op_sel;
    logic [7:0] opnd_a;
    logic [7:0] opnd_b;
    logic [7:0] flags_cur;
    logic       out_valid;
    logic [7:0] res_q;
    logic       res_we;
    logic [7:0] flags_q;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu8_flag_unit i_alu8_flag_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .flags_cur (flags_cur),
        .out_valid (out_valid),
        .res_q     (res_q),
        .res_we    (res_we),
        .flags_q   (flags_q)
    );

    task automatic check(input string tag, input bit ok, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic exp_t model(input logic [3:0] op, input logic [7:0] a,
                                   input logic [7:0] b, input logic [7:0] f);
        exp_t e;
        logic [7:0] r;
        logic c, o, zs;
        int s;
        int n;
        e.fl = {2'b00, f[5:0]};
        r = 8'h00; c = 1'b0; o = 1'b0; zs = 1'b1;
        e.we = 1'b1;
        n = int'(b[2:0]);
        case (op)
            4'd0: r = a & b;
            4'd1: r = a | b;
            4'd2: r = a ^ b;
            4'd3: begin r = a + 8'd1; c = (a == 8'hFF); o = c; end
            4'd4: begin r = a - 8'd1; c = (a == 8'h00); o = c; end
            4'd5: begin
                r = a + b;
                c = (int'(a) + int'(b)) > 255;
                s = int'($signed(a)) + int'($signed(b));
                o = (s > 127) || (s < -128);
            end
            4'd6, 4'd7: begin
                r = a - b;
                c = (a < b);
                s = int'($signed(a)) - int'($signed(b));
                o = (s > 127) || (s < -128);
                if (op == 4'd7) e.we = 1'b0;
            end
            4'd8, 4'd9, 4'd10, 4'd11: begin
                r = a;
                for (int i = 0; i < n; i++) begin
                    case (op)
                        4'd8:    begin c = r[7]; r = {r[6:0], 1'b0}; end
                        4'd9:    begin c = r[0]; r = {1'b0, r[7:1]}; end
                        4'd10:   begin c = r[7]; r = {r[6:0], r[7]}; end
                        default: begin c = r[0]; r = {r[0], r[7:1]}; end
                    endcase
                end
            end
            4'd12: begin r = a; e.we = 1'b0; zs = 1'b0; e.fl[0] = a[n]; end
            default: begin r = 8'h00; e.we = 1'b0; zs = 1'b0; end
        endcase
        if (op <= 4'd7 && op >= 4'd3) begin e.fl[1] = c; e.fl[2] = o; end
        if (op >= 4'd8 && op <= 4'd11) e.fl[1] = c;
        if (zs) begin e.fl[0] = (r == 8'h00); e.fl[3] = r[7]; end
        e.res = r;
        return e;
    endfunction

    // Driver: present one operation and queue its expected outputs
    task automatic send(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] f, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        op_sel    = op;
        opnd_a    = a;
        opnd_b    = b;
        flags_cur = f;
        exp_q.push_back(model(op, a, b, f));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each valid output against the queue head
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected valid", 1'b0, 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {res_q, res_we, flags_q} == e,
                          {15'd0, res_q, res_we, flags_q}, {15'd0, e});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
        flags_cur = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", out_valid == 1'b0, out_valid, 0);
        check("R1 reset result", res_q == 8'h00, res_q, 0);
        check("R1 reset we", res_we == 1'b0, res_we, 0);
        check("R1 reset flags", flags_q == 8'h00, flags_q, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: logic ops with CF/OF set in the input, upper bits set
        send(4'd0, 8'hF0, 8'h0F, 8'hFF, "R3 AND zero");
        send(4'd1, 8'h80, 8'h01, 8'h06, "R3 OR sign");
        send(4'd2, 8'h5A, 8'h5A, 8'hC0, "R3 XOR zero R11 upper");
        // R4 wrap corners and non-wrap
        send(4'd3, 8'hFF, 8'h00, 8'h00, "R4 INC wrap");
        send(4'd3, 8'h7F, 8'h00, 8'h06, "R4 INC no wrap");
        send(4'd4, 8'h00, 8'h00, 8'h00, "R4 DEC wrap");
        send(4'd4, 8'h80, 8'h00, 8'h3F, "R4 DEC no wrap");
        // R5
        send(4'd5, 8'h80, 8'h80, 8'h00, "R5 ADD carry overflow");
        send(4'd5, 8'h7F, 8'h01, 8'h00, "R5 ADD signed overflow");
        send(4'd6, 8'h03, 8'h05, 8'h00, "R5 SUB borrow");
        send(4'd6, 8'h80, 8'h01, 8'h00, "R5 SUB signed overflow");
        // R6
        send(4'd7, 8'h42, 8'h42, 8'h30, "R6 CMP equal");
        send(4'd7, 8'h10, 8'h20, 8'h00, "R6 CMP less R10");
        // R7 and R8
        send(4'd8, 8'h81, 8'h01, 8'h04, "R7 SHL 1");
        send(4'd8, 8'h01, 8'h07, 8'h00, "R7 SHL 7");
        send(4'd9, 8'h03, 8'h02, 8'h04, "R7 SHR 2");
        send(4'd10, 8'h80, 8'h01, 8'h00, "R7 ROL 1");
        send(4'd11, 8'h01, 8'h03, 8'h04, "R7 ROR 3");
        send(4'd8, 8'hA5, 8'h08, 8'h02, "R8 SHL count 0");
        send(4'd11, 8'h00, 8'h00, 8'h02, "R8 ROR count 0");
        // R9
        send(4'd12, 8'h20, 8'h05, 8'h3E, "R9 BIT set");
        send(4'd12, 8'hDF, 8'h05, 8'h01, "R9 BIT clear");
        // R12
        send(4'd13, 8'h12, 8'h34, 8'hFF, "R12 unused 13");
        send(4'd15, 8'h00, 8'h00, 8'h15, "R12 unused 15");
        idle(2);

        // R2: no valid while idle
        @(posedge clk);
        #1;
        check("R2 idle valid", out_valid == 1'b0, out_valid, 0);

        // Mixed sequence with gaps
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a, b, f;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[7:0];
            b = lfsr[15:8] ^ 8'h3C;
            f = lfsr[11:4];
            send(4'(int'(lfsr[7:0]) % 16), a, b, f, "R10 mixed");
            if (lfsr[3:0] == 4'h0) idle(1);
        end
        idle(3);
        check("R2 queue drained", exp_q.size() == 0, exp_q.size(), 0);

        // R1: synchronous reset with an operation pending
        @(negedge clk);
        in_valid = 1'b1; op_sel = 4'd1; opnd_a = 8'hFF; opnd_b = 8'h00;
        flags_cur = 8'h3F; rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 sync reset valid", out_valid == 1'b0, out_valid, 0);
        check("R1 sync reset flags", flags_q == 8'h00, flags_q, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule